// File: doc/BRIEF.md
# Serial Flash Status Register Controller

This block keeps the eight-bit status byte of a serial NOR flash command interface. Inside that byte it holds the write-enable latch, the busy flag, the block protection level, the protection lock and the security-ID lock flag. An opcode decoder sits in front of the block and gives it one strobe per decoded command: read status, write enable, write disable, write status, program, erase, security-ID program and security-ID lockout. The block answers each strobe with a one-cycle accept or reject pulse. It updates the status byte in the same cycle as that pulse.

Program, erase and security-ID program start an internal operation. The block raises BUSY and holds it until the program/erase engine returns a completion pulse. While BUSY is high, every command except read-status is turned away. Completion of a modifying command drops the write-enable latch.

The lockout state of the security-ID space must survive power cycles. This state lives outside the block in a non-volatile bit. The block samples that bit during reset, and it pulses an update request when a lockout completes.

Top module: `fsr_status_top`

## Requirements
- R1: The status byte has BUSY at bit 0, WEL at bit 1, protection level bits at bits 5:2, the security lock flag at bit 6 and the protection lock at bit 7. `protLevel` always equals bits 5:2.
- R2: After reset the status byte reads BUSY=0, WEL=0, protection level 4'hF and protection lock 0. With `nvLocked`=0 this is 8'h3C.
- R3: Bit 6 takes the value of `nvLocked` during reset. With `nvLocked`=1 the reset value is 8'h7C.
- R4: When the block is not busy, write-enable is accepted and sets WEL. Write-disable is accepted and clears WEL.
- R5: Write-status is rejected when WEL=0 and then changes nothing. When it is accepted, it clears WEL.
- R6: An accepted write-status loads the protection lock from `wrData[7]`. It loads the protection level from `wrData[5:2]` only when the protection lock was 0 before the command. Data bits 0, 1 and 6 have no effect.
- R7: Program, erase, security-ID program and lockout are rejected when WEL=0, and the status byte does not change.
- R8: An accepted program, erase or security-ID program sets BUSY in the cycle of its accept pulse. The completion pulse clears BUSY and WEL. A completion pulse while not busy has no effect.
- R9: While BUSY=1, read-status is accepted. Every other command is rejected and leaves bits 7:1 unchanged.
- R10: If a command and the completion pulse arrive in the same cycle, the command is judged as if the block were still busy.
- R11: An accepted lockout sets bit 6, clears WEL and pulses `nvLockSet` for one cycle. Security-ID program is rejected while bit 6 is 1.
- R12: Each command strobe produces exactly one pulse, on `cmdAccept` or on `cmdReject`, in the cycle after the strobe. The two pulses are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| nvLocked | input | 1 | Stored lockout state, sampled during reset |
| cmdRdsr | input | 1 | Read-status strobe |
| cmdWren | input | 1 | Write-enable strobe |
| cmdWrdi | input | 1 | Write-disable strobe |
| cmdWrsr | input | 1 | Write-status strobe |
| cmdProg | input | 1 | Page program strobe (single or dual input) |
| cmdErase | input | 1 | Sector, block or chip erase strobe |
| cmdSidProg | input | 1 | Security-ID program strobe |
| cmdSidLock | input | 1 | Security-ID lockout strobe |
| wrData | input | 8 | Data byte for write-status |
| engineDone | input | 1 | Completion pulse from the program/erase engine |
| statusByte | output | 8 | Current status byte |
| protLevel | output | 4 | Current protection level |
| cmdAccept | output | 1 | One-cycle pulse: command accepted |
| cmdReject | output | 1 | One-cycle pulse: command rejected |
| nvLockSet | output | 1 | One-cycle request to store the lockout state |

## Verification
The completion pulse and a new command strobe can land in the same clock cycle. In that cycle BUSY falls and WEL clears, and the command must still be refused. The bench provokes this by sending write-disable and write-enable strobes together with `engineDone` while an operation is running. It expects a reject pulse and a status byte with both BUSY and WEL low. It also checks that a later write-enable is accepted again.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int STAT_W  = 8;
  localparam int BP_W    = 4;
  localparam int BUSY_IX = 0;
  localparam int WEL_IX  = 1;
  localparam int BP_LO   = 2;
  localparam int BP_HI   = BP_LO + BP_W - 1;
  localparam int SEC_IX  = BP_HI + 1;
  localparam int BPL_IX  = SEC_IX + 1;
  localparam logic [BP_W-1:0] BP_RESET = '1;

  // strobes from control to datapath
  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic loadStat;
    logic setBusy;
    logic clrBusy;
    logic setSec;
  } statStrobe_t;
endpackage

// File: rtl/fsr_datapath.sv
module fsr_datapath
  import fsr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              nvLocked,
  input  statStrobe_t       strb,
  input  logic [STAT_W-1:0] wrData,
  output logic              busy,
  output logic              wel,
  output logic              sec,
  output logic              bpl,
  output logic [BP_W-1:0]   bp,
  output logic [STAT_W-1:0] statusByte
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
    end else if (strb.setBusy) begin
      busy <= 1'b1;
    end else if (strb.clrBusy) begin
      busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wel <= 1'b0;
    end else if (strb.setWel) begin
      wel <= 1'b1;
    end else if (strb.clrWel) begin
      wel <= 1'b0;
    end
  end

  // security lock flag: loaded from stored state at reset, sticky afterwards
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sec <= nvLocked;
    end else if (strb.setSec) begin
      sec <= 1'b1;
    end
  end

  // protection bits: level frozen while the old lock bit is set
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bpl <= 1'b0;
      bp  <= BP_RESET;
    end else if (strb.loadStat) begin
      bpl <= wrData[BPL_IX];
      if (!bpl) begin
        bp <= wrData[BP_HI:BP_LO];
      end
    end
  end

  always_comb begin
    statusByte              = '0;
    statusByte[BUSY_IX]     = busy;
    statusByte[WEL_IX]      = wel;
    statusByte[BP_HI:BP_LO] = bp;
    statusByte[SEC_IX]      = sec;
    statusByte[BPL_IX]      = bpl;
  end

endmodule

// File: rtl/fsr_ctrl.sv
module fsr_ctrl
  import fsr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdRdsr,
  input  logic        cmdWren,
  input  logic        cmdWrdi,
  input  logic        cmdWrsr,
  input  logic        cmdProg,
  input  logic        cmdErase,
  input  logic        cmdSidProg,
  input  logic        cmdSidLock,
  input  logic        engineDone,
  input  logic        busy,
  input  logic        wel,
  input  logic        sec,
  output statStrobe_t strb,
  output logic        cmdAccept,
  output logic        cmdReject,
  output logic        nvLockSet
);

  logic anyCmd;
  logic acceptNow;
  logic lockNow;

  assign anyCmd = cmdRdsr | cmdWren | cmdWrdi | cmdWrsr |
                  cmdProg | cmdErase | cmdSidProg | cmdSidLock;

  always_comb begin
    strb      = '0;
    acceptNow = 1'b0;
    lockNow   = 1'b0;
    if (cmdRdsr) begin
      acceptNow = 1'b1;
    end else if (busy) begin
      acceptNow = 1'b0;
    end else if (cmdWren) begin
      acceptNow   = 1'b1;
      strb.setWel = 1'b1;
    end else if (cmdWrdi) begin
      acceptNow   = 1'b1;
      strb.clrWel = 1'b1;
    end else if (wel) begin
      if (cmdWrsr) begin
        acceptNow     = 1'b1;
        strb.loadStat = 1'b1;
        strb.clrWel   = 1'b1;
      end else if (cmdProg || cmdErase) begin
        acceptNow    = 1'b1;
        strb.setBusy = 1'b1;
      end else if (cmdSidProg && !sec) begin
        acceptNow    = 1'b1;
        strb.setBusy = 1'b1;
      end else if (cmdSidLock) begin
        acceptNow   = 1'b1;
        lockNow     = 1'b1;
        strb.setSec = 1'b1;
        strb.clrWel = 1'b1;
      end
    end
    // completion of an internal operation ends busy and drops the latch
    if (busy && engineDone) begin
      strb.clrBusy = 1'b1;
      strb.clrWel  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdAccept <= 1'b0;
      cmdReject <= 1'b0;
      nvLockSet <= 1'b0;
    end else begin
      cmdAccept <= anyCmd & acceptNow;
      cmdReject <= anyCmd & ~acceptNow;
      nvLockSet <= lockNow;
    end
  end

endmodule

// File: rtl/fsr_status_top.sv
module fsr_status_top
  import fsr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              nvLocked,
  input  logic              cmdRdsr,
  input  logic              cmdWren,
  input  logic              cmdWrdi,
  input  logic              cmdWrsr,
  input  logic              cmdProg,
  input  logic              cmdErase,
  input  logic              cmdSidProg,
  input  logic              cmdSidLock,
  input  logic [STAT_W-1:0] wrData,
  input  logic              engineDone,
  output logic [STAT_W-1:0] statusByte,
  output logic [BP_W-1:0]   protLevel,
  output logic              cmdAccept,
  output logic              cmdReject,
  output logic              nvLockSet
);

  statStrobe_t       strb;
  logic              busy;
  logic              wel;
  logic              sec;
  logic              bpl;
  logic [BP_W-1:0]   bp;

  fsr_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdRdsr    (cmdRdsr),
    .cmdWren    (cmdWren),
    .cmdWrdi    (cmdWrdi),
    .cmdWrsr    (cmdWrsr),
    .cmdProg    (cmdProg),
    .cmdErase   (cmdErase),
    .cmdSidProg (cmdSidProg),
    .cmdSidLock (cmdSidLock),
    .engineDone (engineDone),
    .busy       (busy),
    .wel        (wel),
    .sec        (sec),
    .strb       (strb),
    .cmdAccept  (cmdAccept),
    .cmdReject  (cmdReject),
    .nvLockSet  (nvLockSet)
  );

  fsr_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .nvLocked   (nvLocked),
    .strb       (strb),
    .wrData     (wrData),
    .busy       (busy),
    .wel        (wel),
    .sec        (sec),
    .bpl        (bpl),
    .bp         (bp),
    .statusByte (statusByte)
  );

  assign protLevel = bp;

endmodule

// File: rtl/fsr_status_chk.sv
module fsr_status_chk
  import fsr_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              nvLocked,
  input logic              cmdRdsr,
  input logic              cmdWren,
  input logic              cmdWrdi,
  input logic              cmdWrsr,
  input logic              cmdProg,
  input logic              cmdErase,
  input logic              cmdSidProg,
  input logic              cmdSidLock,
  input logic [STAT_W-1:0] wrData,
  input logic              engineDone,
  input logic [STAT_W-1:0] statusByte,
  input logic [BP_W-1:0]   protLevel,
  input logic              cmdAccept,
  input logic              cmdReject,
  input logic              nvLockSet
);

  logic anyCmd;
  assign anyCmd = cmdRdsr | cmdWren | cmdWrdi | cmdWrsr |
                  cmdProg | cmdErase | cmdSidProg | cmdSidLock;

  p_prot_mirror_r1: assert property (@(posedge clk) disable iff (!rstN)
    protLevel == statusByte[BP_HI:BP_LO]);

  p_bp_frozen_r6: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[BPL_IX] |=> $stable(statusByte[BP_HI:BP_LO]));

  p_busy_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!statusByte[BUSY_IX] && statusByte[WEL_IX] && !cmdRdsr && (cmdProg || cmdErase))
      |=> statusByte[BUSY_IX]);

  p_busy_end_r8: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[BUSY_IX] && engineDone) |=> (!statusByte[BUSY_IX] && !statusByte[WEL_IX]));

  p_busy_freeze_r9: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[BUSY_IX] && !engineDone) |=> $stable(statusByte[STAT_W-1:1]));

  p_busy_reject_r9: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[BUSY_IX] && anyCmd && !cmdRdsr) |=> cmdReject);

  p_sec_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[SEC_IX] |=> statusByte[SEC_IX]);

  p_lock_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    nvLockSet |-> (statusByte[SEC_IX] && cmdAccept && !statusByte[WEL_IX]));

  p_excl_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdAccept && cmdReject));

  p_one_answer_r12: assert property (@(posedge clk) disable iff (!rstN)
    anyCmd |=> (cmdAccept || cmdReject));

  p_no_spurious_r12: assert property (@(posedge clk) disable iff (!rstN)
    !anyCmd |=> (!cmdAccept && !cmdReject));

endmodule

bind fsr_status_top fsr_status_chk i_chk (.*);

// File: tb/test_fsr_status_top.sv
module test_fsr_status_top;
  localparam int CLK_PERIOD = 10;

  localparam int K_RDSR = 0;
  localparam int K_WREN = 1;
  localparam int K_WRDI = 2;
  localparam int K_WRSR = 3;
  localparam int K_PROG = 4;
  localparam int K_ERAS = 5;
  localparam int K_SIDP = 6;
  localparam int K_LOCK = 7;
  localparam int K_NONE = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       nvLocked = 1'b0;
  logic       cmdRdsr = 0, cmdWren = 0, cmdWrdi = 0, cmdWrsr = 0;
  logic       cmdProg = 0, cmdErase = 0, cmdSidProg = 0, cmdSidLock = 0;
  logic [7:0] wrData = '0;
  logic       engineDone = 1'b0;
  logic [7:0] statusByte;
  logic [3:0] protLevel;
  logic       cmdAccept, cmdReject, nvLockSet;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  // reference model state
  bit       mBusy, mWel, mSec, mBpl;
  bit [3:0] mBp;

  typedef struct {
    bit       acc;
    bit       rej;
    bit       nvp;
    bit [7:0] st;
    string    tag;
  } exp_t;
  exp_t q[$];

  fsr_status_top i_fsr_status_top (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit [7:0] mStat();
    return {mBpl, mSec, mBp, mWel, mBusy};
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // monitor: pops expected item after the edge that registers a command
  always @(posedge clk) begin
    exp_t e;
    #2;
    if (q.size() > 0) begin
      e = q.pop_front();
      check(cmdAccept == e.acc, e.tag, "accept", cmdAccept, e.acc);
      check(cmdReject == e.rej, e.tag, "reject", cmdReject, e.rej);
      check(statusByte == e.st, e.tag, "status", statusByte, e.st);
      check(protLevel == e.st[5:2], {e.tag, "/R1"}, "protLevel", protLevel, e.st[5:2]);
      check(nvLockSet == e.nvp, e.tag, "nvLockSet", nvLockSet, e.nvp);
    end
  end

  task automatic clearIns();
    cmdRdsr = 0; cmdWren = 0; cmdWrdi = 0; cmdWrsr = 0;
    cmdProg = 0; cmdErase = 0; cmdSidProg = 0; cmdSidLock = 0;
    engineDone = 0; wrData = '0;
  endtask

  // driver: drives one command (optionally with completion), predicts, pushes
  task automatic issue(int kind, bit [7:0] d, bit done, string tag);
    exp_t e;
    bit acc, nvp;
    @(negedge clk);
    clearIns();
    engineDone = done;
    wrData = d;
    case (kind)
      K_RDSR: cmdRdsr = 1;
      K_WREN: cmdWren = 1;
      K_WRDI: cmdWrdi = 1;
      K_WRSR: cmdWrsr = 1;
      K_PROG: cmdProg = 1;
      K_ERAS: cmdErase = 1;
      K_SIDP: cmdSidProg = 1;
      K_LOCK: cmdSidLock = 1;
      default: ;
    endcase
    acc = 0; nvp = 0;
    if (kind == K_RDSR) acc = 1;
    else if (!mBusy) begin
      if (kind == K_WREN) begin acc = 1; mWel = 1; end
      else if (kind == K_WRDI) begin acc = 1; mWel = 0; end
      else if (mWel) begin
        if (kind == K_WRSR) begin
          acc = 1; mWel = 0;
          if (!mBpl) mBp = d[5:2];
          mBpl = d[7];
        end else if (kind == K_PROG || kind == K_ERAS) begin
          acc = 1; mBusy = 1;
        end else if (kind == K_SIDP && !mSec) begin
          acc = 1; mBusy = 1;
        end else if (kind == K_LOCK) begin
          acc = 1; mSec = 1; mWel = 0; nvp = 1;
        end
      end
    end
    if (done && mBusy && !(acc && (kind == K_PROG || kind == K_ERAS || kind == K_SIDP))) begin
      mBusy = 0; mWel = 0;
    end
    e.acc = (kind != K_NONE) && acc;
    e.rej = (kind != K_NONE) && !acc;
    e.nvp = nvp;
    e.st  = mStat();
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    clearIns();
  endtask

  task automatic doReset(bit nv, string tag);
    @(negedge clk);
    clearIns();
    rstN = 0;
    nvLocked = nv;
    repeat (2) @(negedge clk);
    mBusy = 0; mWel = 0; mBp = 4'hF; mBpl = 0; mSec = nv;
    check(statusByte == mStat(), tag, "reset status", statusByte, mStat());
    rstN = 1;
    @(negedge clk);
    check(statusByte == mStat(), tag, "after release", statusByte, mStat());
    check(!cmdAccept && !cmdReject && !nvLockSet, tag, "idle pulses",
          {cmdAccept, cmdReject, nvLockSet}, 0);
  endtask

  initial begin
    doReset(0, "R2");
    check(statusByte == 8'h3C, "R2", "reset value", statusByte, 8'h3C);

    issue(K_WRSR, 8'h00, 0, "R5 wrsr without wel");
    issue(K_PROG, 8'h00, 0, "R7 prog without wel");
    issue(K_ERAS, 8'h00, 0, "R7 erase without wel");
    issue(K_LOCK, 8'h00, 0, "R7 lock without wel");
    issue(K_WREN, 8'h00, 0, "R4 wren");
    issue(K_WRDI, 8'h00, 0, "R4 wrdi");
    issue(K_WREN, 8'h00, 0, "R4 wren again");
    issue(K_WRSR, 8'h43, 0, "R6 wrsr ignores bits 0,1,6");
    check(statusByte == 8'h00, "R6", "level cleared", statusByte, 8'h00);

    issue(K_WREN, 8'h00, 0, "R4 wren");
    issue(K_PROG, 8'h00, 0, "R8 prog starts busy");
    check(statusByte == 8'h03, "R8", "busy with wel", statusByte, 8'h03);
    issue(K_RDSR, 8'h00, 0, "R9 rdsr while busy");
    issue(K_WREN, 8'h00, 0, "R9 wren while busy");
    issue(K_WRSR, 8'hBC, 0, "R9 wrsr while busy");
    issue(K_WRDI, 8'h00, 1, "R10 wrdi with done");
    check(statusByte == 8'h00, "R10", "busy and wel low", statusByte, 8'h00);
    issue(K_NONE, 8'h00, 1, "R8 stray done");
    issue(K_WREN, 8'h00, 0, "R10 wren after done");

    issue(K_ERAS, 8'h00, 0, "R8 erase starts busy");
    issue(K_WREN, 8'h00, 1, "R10 wren with done");
    issue(K_WREN, 8'h00, 0, "R4 wren");
    issue(K_WRSR, 8'hBC, 0, "R6 set lock and level");
    issue(K_WREN, 8'h00, 0, "R4 wren");
    issue(K_WRSR, 8'h80, 0, "R6 level frozen");
    check(protLevel == 4'hF, "R6", "frozen level", protLevel, 4'hF);
    issue(K_WREN, 8'h00, 0, "R4 wren");
    issue(K_WRSR, 8'h00, 0, "R6 unlock keeps level");
    issue(K_WREN, 8'h00, 0, "R4 wren");
    issue(K_WRSR, 8'h14, 0, "R6 level write after unlock");
    check(protLevel == 4'h5, "R1", "level value", protLevel, 4'h5);

    issue(K_WREN, 8'h00, 0, "R4 wren");
    issue(K_SIDP, 8'h00, 0, "R8 sid program");
    issue(K_NONE, 8'h00, 1, "R8 sid done");
    issue(K_WREN, 8'h00, 0, "R4 wren");
    issue(K_LOCK, 8'h00, 0, "R11 lockout");
    issue(K_WREN, 8'h00, 0, "R4 wren");
    issue(K_SIDP, 8'h00, 0, "R11 sid program after lock");
    issue(K_WRDI, 8'h00, 0, "R4 wrdi");
    repeat (3) @(negedge clk);

    doReset(1, "R3");
    check(statusByte == 8'h7C, "R3", "locked reset value", statusByte, 8'h7C);
    issue(K_WREN, 8'h00, 0, "R4 wren");
    issue(K_SIDP, 8'h00, 0, "R11 sid program when stored locked");
    issue(K_RDSR, 8'h00, 0, "R12 rdsr idle");
    repeat (3) @(negedge clk);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule